// File: doc/BRIEF.md
# Serial Divider Programming Port

This block receives configuration words for a frequency synthesizer over a three-wire serial link: a serial clock, a serial data line and a load strobe. Every rising serial-clock edge moves one data bit into a 19-bit shift register, most significant bit first. The bit shifted in last is a destination selector. When the load strobe rises, the stored word is copied into one of two register sets, and the selector bit chooses which one.

The reference set holds the 14-bit reference divide ratio and four mode bits: prescaler modulus select, phase-detector polarity, monitor-output select and charge-pump current select. The main set holds the 7-bit swallow count and the 11-bit main counter ratio. The divider chain, the phase comparator and the charge pump read these fields directly.

All three serial pins are treated as asynchronous. Each passes through a synchronizer of `SYNC_STAGES` flops into the `clk` domain, and edges are detected there. The serial link is a write-only control path. It has no valid/ready handshake and no back-pressure, so the sender has to hold each level for at least `SYNC_STAGES + 1` periods of `clk`.

Top module: `serial_prog_port`

## Requirements
- R1: The port shifts one `ser_data` bit on each rising `ser_clk` edge while `ser_load` is low. The first bit sent ends up in word position 19 and the last bit sent in position 1.
- R2: Word position 1 selects the destination: 1 selects the reference set and 0 selects the main set. A load never alters the set that was not selected.
- R3: On a reference load, positions 2..15 become `ref_div` (position 2 is its LSB). Position 16 becomes `pre_sel`, 17 becomes `pd_pol`, 18 becomes `mon_sel` and 19 becomes `cp_hi`.
- R4: On a main load, positions 2..8 become `swallow` (position 2 is its LSB) and positions 9..19 become `main_div` (position 9 is its LSB).
- R5: A transfer happens once per rising edge of `ser_load`. Holding `ser_load` high does not reload, and outputs change only on such a transfer.
- R6: Serial clock edges that arrive while `ser_load` is high do not shift, so they do not change the word that the next transfer uses.
- R7: After reset every field output and both flags are 0.
- R8: `ref_bad` shows whether the last reference load carried a ratio below 3. `main_bad` does the same for the last main load. Each flag is updated only by a load of its own set.
- R9: When more than 19 bits are clocked in before a load, only the last 19 count; earlier bits fall off the top.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk | input | 1 | Serial bit clock (asynchronous) |
| ser_data | input | 1 | Serial data bit |
| ser_load | input | 1 | Load strobe; its rising edge transfers the word |
| ref_div | output | 14 | Reference divide ratio |
| pre_sel | output | 1 | Prescaler modulus select |
| pd_pol | output | 1 | Phase-detector polarity |
| mon_sel | output | 1 | Monitor-output select |
| cp_hi | output | 1 | Charge-pump high-current select |
| swallow | output | 7 | Swallow count |
| main_div | output | 11 | Main counter ratio |
| ref_bad | output | 1 | Last reference ratio below 3 |
| main_bad | output | 1 | Last main ratio below 3 |

## Verification
The bench targets the bit order and field slicing with asymmetric values such as ratio 1000 and count 5. A reversed shift or a field shifted by one bit would show up in every field at once. It raises the load strobe and then keeps clocking; a design that shifts while the strobe is high would then steer the following reload into the wrong set. It sends more than 19 bits before a load, holds the strobe high for a long time, and loads ratios of 2 next to legal ones. A design that reloads on a level, keeps stale bits, or lets one set's flag follow the other set would fail these cases.

// File: rtl/sp_pkg.sv
package sp_pkg;
  typedef enum logic {
    DST_MAIN = 1'b0,
    DST_REF  = 1'b1
  } dst_e;

  localparam int unsigned MIN_RATIO = 3;
endpackage

// File: rtl/sp_sync.sv
module sp_sync #(
  parameter int unsigned W      = 3,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] stg [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) stg[i] <= '0;
        else        stg[i] <= din;
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) stg[i] <= '0;
        else        stg[i] <= stg[i-1];
    end
  end

  assign dout = stg[STAGES-1];
endmodule

// File: rtl/sp_shifter.sv
module sp_shifter #(
  parameter int unsigned W = 19
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         shift_en,
  input  logic         bit_in,
  output logic [W-1:0] word
);
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)        word <= '0;
    else if (shift_en) word <= {word[W-2:0], bit_in};
endmodule

// File: rtl/sp_latch_bank.sv
module sp_latch_bank
  import sp_pkg::*;
#(
  parameter int unsigned R_W = 14,
  parameter int unsigned A_W = 7,
  parameter int unsigned N_W = 11,
  localparam int unsigned W  = 1 + R_W + 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load,
  input  logic [W-1:0]   word,
  output logic [R_W-1:0] ref_div,
  output logic           pre_sel,
  output logic           pd_pol,
  output logic           mon_sel,
  output logic           cp_hi,
  output logic [A_W-1:0] swallow,
  output logic [N_W-1:0] main_div,
  output logic           ref_bad,
  output logic           main_bad
);
  localparam int unsigned MODE_LSB = R_W + 1;

  logic [R_W-1:0] r_fld;
  logic [A_W-1:0] a_fld;
  logic [N_W-1:0] n_fld;
  logic           to_ref;

  assign to_ref = (word[0] == DST_REF);
  assign r_fld  = word[R_W:1];
  assign a_fld  = word[A_W:1];
  assign n_fld  = word[A_W+N_W:A_W+1];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ref_div <= '0;
      pre_sel <= 1'b0;
      pd_pol  <= 1'b0;
      mon_sel <= 1'b0;
      cp_hi   <= 1'b0;
      ref_bad <= 1'b0;
    end else if (load && to_ref) begin
      ref_div <= r_fld;
      pre_sel <= word[MODE_LSB];
      pd_pol  <= word[MODE_LSB+1];
      mon_sel <= word[MODE_LSB+2];
      cp_hi   <= word[MODE_LSB+3];
      ref_bad <= (r_fld < R_W'(MIN_RATIO));
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      swallow  <= '0;
      main_div <= '0;
      main_bad <= 1'b0;
    end else if (load && !to_ref) begin
      swallow  <= a_fld;
      main_div <= n_fld;
      main_bad <= (n_fld < N_W'(MIN_RATIO));
    end
endmodule

// File: rtl/serial_prog_port.sv
module serial_prog_port #(
  parameter int unsigned R_W         = 14,
  parameter int unsigned A_W         = 7,
  parameter int unsigned N_W         = 11,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           ser_clk,
  input  logic           ser_data,
  input  logic           ser_load,
  output logic [R_W-1:0] ref_div,
  output logic           pre_sel,
  output logic           pd_pol,
  output logic           mon_sel,
  output logic           cp_hi,
  output logic [A_W-1:0] swallow,
  output logic [N_W-1:0] main_div,
  output logic           ref_bad,
  output logic           main_bad
);
  localparam int unsigned WORD_W = 1 + R_W + 4;

  logic [2:0]        pins_s;
  logic              sclk_s, sdata_s, le_s;
  logic              sclk_q, le_q;
  logic              sclk_rise, le_rise, shift_en;
  logic [WORD_W-1:0] sr_word;

  sp_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  ({ser_load, ser_data, ser_clk}),
    .dout (pins_s)
  );

  assign sclk_s  = pins_s[0];
  assign sdata_s = pins_s[1];
  assign le_s    = pins_s[2];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sclk_q <= 1'b0;
      le_q   <= 1'b0;
    end else begin
      sclk_q <= sclk_s;
      le_q   <= le_s;
    end

  assign sclk_rise = sclk_s & ~sclk_q;
  assign le_rise   = le_s & ~le_q;
  assign shift_en  = sclk_rise & ~le_s;

  sp_shifter #(.W(WORD_W)) u_shift (
    .clk     (clk),
    .rst_n   (rst_n),
    .shift_en(shift_en),
    .bit_in  (sdata_s),
    .word    (sr_word)
  );

  sp_latch_bank #(.R_W(R_W), .A_W(A_W), .N_W(N_W)) u_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (le_rise),
    .word    (sr_word),
    .ref_div (ref_div),
    .pre_sel (pre_sel),
    .pd_pol  (pd_pol),
    .mon_sel (mon_sel),
    .cp_hi   (cp_hi),
    .swallow (swallow),
    .main_div(main_div),
    .ref_bad (ref_bad),
    .main_bad(main_bad)
  );
endmodule

// File: rtl/serial_prog_port_chk.sv
module serial_prog_port_chk #(
  parameter int unsigned R_W = 14,
  parameter int unsigned A_W = 7,
  parameter int unsigned N_W = 11,
  localparam int unsigned WORD_W = 1 + R_W + 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              le_rise,
  input logic              le_s,
  input logic              sclk_rise,
  input logic [WORD_W-1:0] sr_word,
  input logic [R_W-1:0]    ref_div,
  input logic              pre_sel,
  input logic              pd_pol,
  input logic              mon_sel,
  input logic              cp_hi,
  input logic [A_W-1:0]    swallow,
  input logic [N_W-1:0]    main_div,
  input logic              ref_bad,
  input logic              main_bad
);
  logic [R_W+4:0]     ref_set;
  logic [A_W+N_W-1:0] main_set;
  assign ref_set  = {ref_div, pre_sel, pd_pol, mon_sel, cp_hi, ref_bad};
  assign main_set = {swallow, main_div};

  p_ref_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !le_rise |=> $stable(ref_set));

  p_main_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !le_rise |=> $stable({main_set, main_bad}));

  p_one_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(!$stable(ref_set) && !$stable(main_set)));

  p_no_shift_high_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (le_s && sclk_rise) |=> $stable(sr_word));

  p_ref_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ref_bad |-> (ref_div < R_W'(3)));

  p_main_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
    main_bad |-> (main_div < N_W'(3)));
endmodule

bind serial_prog_port serial_prog_port_chk #(.R_W(R_W), .A_W(A_W), .N_W(N_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .le_rise  (le_rise),
  .le_s     (le_s),
  .sclk_rise(sclk_rise),
  .sr_word  (sr_word),
  .ref_div  (ref_div),
  .pre_sel  (pre_sel),
  .pd_pol   (pd_pol),
  .mon_sel  (mon_sel),
  .cp_hi    (cp_hi),
  .swallow  (swallow),
  .main_div (main_div),
  .ref_bad  (ref_bad),
  .main_bad (main_bad)
);

// File: tb/serial_prog_port_tb.sv
module serial_prog_port_tb;
  localparam int SYNC = 2;
  localparam int HOLD = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ser_clk = 1'b0, ser_data = 1'b0, ser_load = 1'b0;
  logic [13:0] ref_div;
  logic        pre_sel, pd_pol, mon_sel, cp_hi, ref_bad, main_bad;
  logic [6:0]  swallow;
  logic [10:0] main_div;

  always #10 clk = ~clk;

  serial_prog_port #(.SYNC_STAGES(SYNC)) u_dut (
    .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_data(ser_data),
    .ser_load(ser_load), .ref_div(ref_div), .pre_sel(pre_sel),
    .pd_pol(pd_pol), .mon_sel(mon_sel), .cp_hi(cp_hi), .swallow(swallow),
    .main_div(main_div), .ref_bad(ref_bad), .main_bad(main_bad)
  );

  int n_cmp = 0, n_bad = 0, cycles = 0;

  task automatic chk(string req, string what, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  // Behavioural reference model
  logic [2:0]  hist[$];
  logic [18:0] m_sr = '0;
  logic        m_pclk = 0, m_ple = 0;
  int m_ref = 0, m_sw = 0, m_fc = 0, m_lds = 0, m_cs = 0, m_a = 0, m_n = 0;
  int m_rbad = 0, m_nbad = 0;

  function automatic logic [2:0] seen(int i);
    return (i < hist.size()) ? hist[i] : 3'b000;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      hist.delete();
      m_sr = '0; m_pclk = 0; m_ple = 0;
      m_ref = 0; m_sw = 0; m_fc = 0; m_lds = 0; m_cs = 0;
      m_a = 0; m_n = 0; m_rbad = 0; m_nbad = 0;
    end else begin
      logic [2:0] s;
      s = seen(SYNC - 1);
      if (s[2] && !m_ple) begin
        if (m_sr[0]) begin
          m_ref = int'(m_sr[14:1]); m_sw = m_sr[15]; m_fc = m_sr[16];
          m_lds = m_sr[17]; m_cs = m_sr[18]; m_rbad = (m_ref < 3);
        end else begin
          m_a = int'(m_sr[7:1]); m_n = int'(m_sr[18:8]); m_nbad = (m_n < 3);
        end
      end else if (s[0] && !m_pclk && !s[2]) begin
        m_sr = {m_sr[17:0], s[1]};
      end
      m_pclk = s[0];
      m_ple  = s[2];
    end
    hist.push_front({ser_load, ser_data, ser_clk});
  end

  always @(negedge clk) begin
    if (rst_n) begin
      chk("R3", "ref_div", ref_div, m_ref);
      chk("R3", "mode bits", {pre_sel, pd_pol, mon_sel, cp_hi},
          {m_sw[0], m_fc[0], m_lds[0], m_cs[0]});
      chk("R4", "swallow", swallow, m_a);
      chk("R4", "main_div", main_div, m_n);
      chk("R8", "flags", {ref_bad, main_bad}, {m_rbad[0], m_nbad[0]});
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles == 100000) begin
      n_bad++;
      $display("FAIL watchdog: actual %0d expected <100000 cycles", cycles);
      finish_run();
    end
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bits(logic [31:0] v, int nbits);
    for (int i = nbits - 1; i >= 0; i--) begin
      ser_data = v[i];
      idle(HOLD); ser_clk = 1'b1;
      idle(HOLD); ser_clk = 1'b0;
    end
  endtask

  task automatic pulse_load();
    ser_load = 1'b1; idle(HOLD);
    ser_load = 1'b0; idle(HOLD);
  endtask

  function automatic logic [18:0] ref_word(int r, bit sw, bit fc, bit lds, bit cs);
    return {cs, lds, fc, sw, r[13:0], 1'b1};
  endfunction

  function automatic logic [18:0] main_word(int a, int n);
    return {n[10:0], a[6:0], 1'b0};
  endfunction

  initial begin
    idle(5);
    chk("R7", "reset ref_div", ref_div, 0);
    chk("R7", "reset main", {swallow, main_div}, 0);
    chk("R7", "reset flags", {ref_bad, main_bad}, 0);
    rst_n = 1'b1;
    idle(3);

    // R1 R2 R3: reference load with asymmetric values
    send_bits(32'(ref_word(1000, 1, 0, 1, 1)), 19); pulse_load();
    chk("R3", "ref_div", ref_div, 1000);
    chk("R3", "sw/fc/lds/cs", {pre_sel, pd_pol, mon_sel, cp_hi}, 4'b1011);
    chk("R2", "main untouched", {swallow, main_div}, 0);

    // R1 R4: main load
    send_bits(32'(main_word(5, 300)), 19); pulse_load();
    chk("R4", "swallow", swallow, 5);
    chk("R4", "main_div", main_div, 300);
    chk("R2", "ref untouched", ref_div, 1000);

    // R6: clocking while load is high must not shift
    ser_load = 1'b1; idle(HOLD);
    for (int k = 0; k < 5; k++) begin
      ser_data = 1'b1; idle(HOLD); ser_clk = 1'b1; idle(HOLD); ser_clk = 1'b0;
    end
    ser_load = 1'b0; idle(HOLD);
    pulse_load();
    chk("R6", "ref after high clocks", ref_div, 1000);
    chk("R6", "main after high clocks", main_div, 300);

    // R5: held load performs a single transfer
    send_bits(32'(main_word(127, 2047)), 19);
    ser_load = 1'b1; idle(HOLD);
    chk("R5", "main after rise", main_div, 2047);
    idle(20);
    chk("R5", "swallow while held", swallow, 127);
    ser_load = 1'b0; idle(HOLD);

    // R8: illegal ratios flagged per set
    send_bits(32'(ref_word(2, 0, 1, 0, 0)), 19); pulse_load();
    chk("R8", "ref_bad on R=2", ref_bad, 1);
    chk("R8", "main_bad unaffected", main_bad, 0);
    send_bits(32'(main_word(0, 2)), 19); pulse_load();
    chk("R8", "main_bad on N=2", main_bad, 1);
    send_bits(32'(main_word(3, 3)), 19); pulse_load();
    chk("R8", "main_bad cleared N=3", main_bad, 0);
    chk("R8", "ref_bad kept", ref_bad, 1);
    send_bits(32'(ref_word(3, 0, 0, 0, 1)), 19); pulse_load();
    chk("R8", "ref_bad cleared R=3", ref_bad, 0);

    // R9: extra leading bits fall off
    send_bits(32'h3F, 6);
    send_bits(32'(main_word(64, 1024)), 19); pulse_load();
    chk("R9", "swallow after overlong", swallow, 64);
    chk("R9", "main_div after overlong", main_div, 1024);
    chk("R1", "MSB-first mode bit cs", cp_hi, 1);

    idle(10);
    finish_run();
  end
endmodule